// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer for a system-on-chip, attached to a simple single-cycle register bus clocked by `pclk`. Software configures it through two key-guarded registers. The mode register sets enable, the action on expiry and the reset pulse length. The control register sets the prescaler select and a 12-bit reload value. Software then keeps the timer alive by writing a fixed restart key. A write to a guarded register whose key field does not match is dropped silently. A restart with any value other than the key does nothing.

The down-counter is 24 bits wide. Its upper 12 bits come from the reload field and its lower 12 bits fill with ones on every restart. Each reload step is therefore worth 4096 prescaled ticks. When the count runs down to zero while the timer is enabled, a sticky expiry flag is set. That flag drives an interrupt level when interrupts are enabled. When the reset enable is set, the same expiry also launches one system reset pulse of programmable width.

Top module: `keyed_wdt`

## Requirements
- R1: After the synchronous reset, the mode register reads 0x0, the control register reads 0x3FFF (reload 0xFFF, select 3), the status register reads 0, and both `irq_o` and `wdt_rst_o` are low.
- R2: A write to offset 0x0 (mode) is accepted only when wdata[23:12] equals 0xABC. Bit 0 is enable, bit 1 is reset enable, bit 2 is interrupt enable and bits [5:4] are the pulse length code. A read returns these fields with every other bit zero.
- R3: A write to offset 0x4 (control) is accepted only when wdata[25:14] equals 0x248, which is the pattern 0x00920000. Bits [13:2] are the reload value and bits [1:0] are the prescale select. A read returns these fields with every other bit zero.
- R4: A write of exactly 0x00001999 to offset 0x8 (restart) loads the counter with {reload, 12'hFFF}, restarts the prescaler from zero and clears the expiry flag. Any other value written there has no effect. Offset 0x8 reads as 0.
- R5: Each counter decrement takes 8, 64, 512 or 4096 pclk cycles for prescale select 0, 1, 2 or 3 respectively.
- R6: Suppose enable is set and a restart is accepted at clock edge E. The expiry flag, which is status bit 0 at offset 0xC, then reads 1 from edge E + div*(reload*4096 + 4095) onward. It stays at 1 until the next accepted restart.
- R7: `irq_o` is a level equal to the expiry flag ANDed with the interrupt enable.
- R8: If the reset enable is set, an expiry makes `wdt_rst_o` high from the cycle after the expiry edge. The pulse lasts 2, 4, 8 or 16 cycles for length code 0, 1, 2 or 3. If the reset enable is clear, no pulse is produced.
- R9: While enable is clear, the counter and the prescaler hold their values and no expiry occurs.
- R10: If an accepted restart lands on the same edge as the final decrement, the restart wins. The expiry flag stays clear, no reset pulse is produced, and a full new period begins at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data including key fields |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Expiry interrupt level |
| wdt_rst_o | output | 1 | Expiry reset pulse |

## Verification
A restart write and the final counter decrement can arrive on the same clock edge. The bench provokes this by issuing a first restart and then timing a second restart so that its write edge falls exactly on the edge where the count would reach zero. At that point it checks that the status read stays 0 and that `wdt_rst_o` stays low. It then waits one more full period and checks that expiry arrives exactly on schedule from the colliding edge, with a two-cycle pulse, which confirms that the restart took priority and reloaded the counter.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    localparam int RELOAD_W = 12;
    localparam int PRE_W    = 12;
    localparam int PLS_W    = 5;

    localparam logic [11:0] MODE_KEY  = 12'hABC;
    localparam logic [11:0] CTRL_KEY  = 12'h248;
    localparam logic [31:0] KICK_WORD = 32'h0000_1999;

    localparam logic [3:0] OFF_MODE = 4'h0;
    localparam logic [3:0] OFF_CTRL = 4'h4;
    localparam logic [3:0] OFF_KICK = 4'h8;
    localparam logic [3:0] OFF_STAT = 4'hC;

    typedef struct packed {
        logic [1:0] plen;
        logic       irq_en;
        logic       rst_en;
        logic       en;
    } mode_t;

    typedef struct packed {
        logic [RELOAD_W-1:0] reload;
        logic [1:0]          psel;
    } ctrl_t;

    localparam mode_t MODE_RST = '{plen: 2'd0, irq_en: 1'b0, rst_en: 1'b0, en: 1'b0};
    localparam ctrl_t CTRL_RST = '{reload: {RELOAD_W{1'b1}}, psel: 2'd3};

    function automatic logic [PRE_W-1:0] pre_term(input logic [1:0] sel);
        logic [PRE_W-1:0] t;
        case (sel)
            2'd0:    t = PRE_W'(7);
            2'd1:    t = PRE_W'(63);
            2'd2:    t = PRE_W'(511);
            default: t = PRE_W'(4095);
        endcase
        return t;
    endfunction

    function automatic logic [PLS_W-1:0] pulse_len(input logic [1:0] code);
        return PLS_W'(2) << code;
    endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import keyed_wdt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              expired,
    output logic [31:0]       rdata,
    output mode_t             mode,
    output ctrl_t             ctrl,
    output logic              kick
);

    logic  hit_mode, hit_ctrl, hit_kick, hit_stat;
    logic  mode_ok, ctrl_ok;
    mode_t mode_q;
    ctrl_t ctrl_q;

    assign hit_mode = (addr == ADDR_W'(OFF_MODE));
    assign hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
    assign hit_kick = (addr == ADDR_W'(OFF_KICK));
    assign hit_stat = (addr == ADDR_W'(OFF_STAT));

    assign mode_ok = wr && hit_mode && (wdata[23:12] == MODE_KEY);
    assign ctrl_ok = wr && hit_ctrl && (wdata[25:14] == CTRL_KEY);
    assign kick    = wr && hit_kick && (wdata == KICK_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RST;
            ctrl_q <= CTRL_RST;
        end else begin
            if (mode_ok) begin
                mode_q.plen   <= wdata[5:4];
                mode_q.irq_en <= wdata[2];
                mode_q.rst_en <= wdata[1];
                mode_q.en     <= wdata[0];
            end
            if (ctrl_ok) begin
                ctrl_q.reload <= wdata[2+RELOAD_W-1:2];
                ctrl_q.psel   <= wdata[1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_mode) begin
            rdata[5:4] = mode_q.plen;
            rdata[2]   = mode_q.irq_en;
            rdata[1]   = mode_q.rst_en;
            rdata[0]   = mode_q.en;
        end else if (hit_ctrl) begin
            rdata[2+RELOAD_W-1:2] = ctrl_q.reload;
            rdata[1:0]            = ctrl_q.psel;
        end else if (hit_stat) begin
            rdata[0] = expired;
        end
    end

    assign mode = mode_q;
    assign ctrl = ctrl_q;

endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale
    import keyed_wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] term;
    logic             at_end;

    assign term   = pre_term(sel);
    assign at_end = (pre_q >= term);
    assign tick   = en && at_end;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (en) begin
            pre_q <= at_end ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import keyed_wdt_pkg::*;
#(
    parameter int LOW_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                tick,
    input  logic                kick,
    input  logic [RELOAD_W-1:0] reload,
    output logic                expired,
    output logic                fire,
    output logic [RELOAD_W+LOW_W-1:0] count
);

    localparam int CNT_W = RELOAD_W + LOW_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             exp_q;
    logic             step;

    assign step = en && tick && (cnt_q != '0);
    assign fire = step && (cnt_q == ONE) && !kick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= {CTRL_RST.reload, {LOW_W{1'b1}}};
            exp_q <= 1'b0;
        end else if (kick) begin
            cnt_q <= {reload, {LOW_W{1'b1}}};
            exp_q <= 1'b0;
        end else if (step) begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) begin
                exp_q <= 1'b1;
            end
        end
    end

    assign expired = exp_q;
    assign count   = cnt_q;

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse
    import keyed_wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic [1:0] code,
    output logic       pulse
);

    logic [PLS_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= pulse_len(code);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse = (left_q != '0);

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LOW_W  = 12
) (
    input  logic              pclk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              wdt_rst_o
);

    localparam int CNT_W = RELOAD_W + LOW_W;

    mode_t            mode_q;
    ctrl_t            ctrl_q;
    logic             kick;
    logic             tick;
    logic             expired_q;
    logic             fire;
    logic [CNT_W-1:0] count_q;

    kwdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (pclk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .expired (expired_q),
        .rdata   (bus_rdata),
        .mode    (mode_q),
        .ctrl    (ctrl_q),
        .kick    (kick)
    );

    kwdt_prescale u_pre (
        .clk  (pclk),
        .rst  (rst),
        .clr  (kick),
        .en   (mode_q.en),
        .sel  (ctrl_q.psel),
        .tick (tick)
    );

    kwdt_counter #(.LOW_W(LOW_W)) u_cnt (
        .clk     (pclk),
        .rst     (rst),
        .en      (mode_q.en),
        .tick    (tick),
        .kick    (kick),
        .reload  (ctrl_q.reload),
        .expired (expired_q),
        .fire    (fire),
        .count   (count_q)
    );

    kwdt_pulse u_pls (
        .clk   (pclk),
        .rst   (rst),
        .fire  (fire && mode_q.rst_en),
        .code  (mode_q.plen),
        .pulse (wdt_rst_o)
    );

    assign irq_o = expired_q && mode_q.irq_en;

endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
    import keyed_wdt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq_o,
    input logic              wdt_rst_o,
    input mode_t             mode_q,
    input ctrl_t             ctrl_q,
    input logic              expired_q,
    input logic [CNT_W-1:0]  count_q
);

    logic       good_kick;
    logic [5:0] run_q;

    assign good_kick = bus_wr && (bus_addr == ADDR_W'(OFF_KICK)) && (bus_wdata == KICK_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (wdt_rst_o) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    a_r2_mode_key: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFF_MODE) && bus_wdata[23:12] != MODE_KEY) |=> $stable(mode_q));

    a_r3_ctrl_key: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[25:14] != CTRL_KEY) |=> $stable(ctrl_q));

    a_r4_kick_clears: assert property (@(posedge clk) disable iff (rst)
        good_kick |=> !expired_q);

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (expired_q && !good_kick) |=> expired_q);

    a_r7_irq_gate: assert property (@(posedge clk) disable iff (rst)
        !mode_q.irq_en |-> !irq_o);

    a_r8_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_rst_o) |-> $past(mode_q.rst_en));

    a_r8_max_width: assert property (@(posedge clk) disable iff (rst)
        run_q <= 6'd16);

    a_r9_hold_off: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.en && !good_kick) |=> $stable(count_q));

    a_r10_kick_wins: assert property (@(posedge clk) disable iff (rst)
        good_kick |=> !$rose(wdt_rst_o) && !expired_q);

endmodule

bind keyed_wdt keyed_wdt_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (pclk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .wdt_rst_o (wdt_rst_o),
    .mode_q    (mode_q),
    .ctrl_q    (ctrl_q),
    .expired_q (expired_q),
    .count_q   (count_q)
);

// File: tb/sim_keyed_wdt.sv
`timescale 1ns/1ps
module sim_keyed_wdt;

    logic        pclk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        wdt_rst_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam int PERIOD8 = 8 * 4095;

    localparam logic [67:0] VEC [7] = '{
        {4'h0, 32'h00AB_C036, 32'h0000_0036},
        {4'h0, 32'h00AB_B001, 32'h0000_0036},
        {4'h4, 32'h0092_1696, 32'h0000_1696},
        {4'h4, 32'h0091_0003, 32'h0000_1696},
        {4'h4, 32'h0092_3FFD, 32'h0000_3FFD},
        {4'h0, 32'hFFAB_C010, 32'h0000_0010},
        {4'h4, 32'hFC92_0000, 32'h0000_0000}
    };

    always #2.5 pclk = ~pclk;

    keyed_wdt u0 (
        .pclk      (pclk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .wdt_rst_o (wdt_rst_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge pclk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge pclk);
        bus_wr    = 1'b0;
        bus_addr  = 4'hC;
        bus_wdata = '0;
        #1;
    endtask

    task automatic read_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_addr = 4'hC;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge pclk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = 4'hC; bus_wdata = '0;
        repeat (4) @(negedge pclk);
        rst = 1'b0;
        #1;

        // R1 reset state
        read_check("R1 mode", 4'h0, 32'h0);
        read_check("R1 ctrl", 4'h4, 32'h3FFF);
        read_check("R1 status", 4'hC, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 rst_o", {31'b0, wdt_rst_o}, 32'h0);

        // R2 R3 register and key table
        for (int i = 0; i < 7; i++) begin
            bus_write(VEC[i][67:64], VEC[i][63:32]);
            read_check($sformatf("R2/R3 vec%0d", i), VEC[i][67:64], VEC[i][31:0]);
        end
        read_check("R4 restart reads zero", 4'h8, 32'h0);

        // R5 R6 R8: select 0, reload 0, reset pulse code 3
        bus_write(4'h4, 32'h0092_0000);
        bus_write(4'h0, 32'h00AB_C033);
        bus_write(4'h8, 32'h0000_1999);
        check("R4 kick clears status", bus_rdata, 32'h0);
        repeat (PERIOD8 - 1) @(negedge pclk);
        #1;
        check("R6 not early", bus_rdata, 32'h0);
        @(negedge pclk); #1;
        check("R5 R6 expiry on time", bus_rdata, 32'h1);
        check("R8 pulse starts", {31'b0, wdt_rst_o}, 32'h1);
        check("R7 irq off when disabled", {31'b0, irq_o}, 32'h0);
        repeat (15) @(negedge pclk);
        #1;
        check("R8 pulse 16th cycle", {31'b0, wdt_rst_o}, 32'h1);
        @(negedge pclk); #1;
        check("R8 pulse ends after 16", {31'b0, wdt_rst_o}, 32'h0);

        // R4 wrong restart value
        bus_write(4'h8, 32'h0000_1998);
        check("R4 bad kick ignored", bus_rdata, 32'h1);
        bus_write(4'h0, 32'h00AB_C007);
        check("R7 irq level", {31'b0, irq_o}, 32'h1);

        // R10 restart colliding with final decrement
        bus_write(4'h8, 32'h0000_1999);
        check("R4 kick clears irq", {31'b0, irq_o}, 32'h0);
        repeat (PERIOD8 - 2) @(negedge pclk);
        bus_write(4'h8, 32'h0000_1999);
        check("R10 no expiry", bus_rdata, 32'h0);
        check("R10 no pulse", {31'b0, wdt_rst_o}, 32'h0);
        repeat (PERIOD8 - 1) @(negedge pclk);
        #1;
        check("R10 new period not early", bus_rdata, 32'h0);
        @(negedge pclk); #1;
        check("R10 new period expiry", bus_rdata, 32'h1);
        check("R8 code0 pulse start", {31'b0, wdt_rst_o}, 32'h1);
        check("R7 irq with enable", {31'b0, irq_o}, 32'h1);
        @(negedge pclk); #1;
        check("R8 code0 second cycle", {31'b0, wdt_rst_o}, 32'h1);
        @(negedge pclk); #1;
        check("R8 code0 ends", {31'b0, wdt_rst_o}, 32'h0);
        bus_write(4'h0, 32'h00AB_C003);
        check("R7 irq masked", {31'b0, irq_o}, 32'h0);
        check("R6 status held", bus_rdata, 32'h1);

        // R9 disabled timer does not expire
        bus_write(4'h8, 32'h0000_1999);
        bus_write(4'h0, 32'h00AB_C002);
        repeat (33000) @(negedge pclk);
        #1;
        check("R9 no expiry while off", bus_rdata, 32'h0);
        check("R9 no pulse while off", {31'b0, wdt_rst_o}, 32'h0);

        // R5 select 1 is slower than select 0
        bus_write(4'h4, 32'h0092_0001);
        bus_write(4'h0, 32'h00AB_C003);
        bus_write(4'h8, 32'h0000_1999);
        repeat (33000) @(negedge pclk);
        #1;
        check("R5 div64 not expired", bus_rdata, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule